// File: doc/BRIEF.md
# Hysteresis Frequency and Peak Meter

This block measures the frequency of a slowly varying analog signal from a stream of converter samples. A sample enters on `smp_data` whenever `smp_valid` is high. A `start` pulse opens a gate window of `gate_len` system clocks. During that window every accepted sample passes through a software-style Schmitt trigger with a persistence filter. A signal cycle is counted only after a run of samples stays above a high threshold long enough to arm the trigger, followed by a sample that is exactly zero.

The same samples also feed a peak tracker and a sample counter. When the window closes, `busy` falls and `done` rises. The frequency count, the largest sample, the smallest sample and the number of accepted samples then hold on the outputs until the next `start`. The threshold and the persistence length are runtime inputs, captured when `start` is seen. The gate length is also captured at `start`. Its default is sized for one second of system clock.

Top module: `hyst_freq_meter`

## Requirements
- R1: In the cycle after a `start` edge, `busy` is 1, `done` is 0, `freq_cnt` and `smp_cnt` are 0, `max_val` is 0 and `min_val` is all ones (1023 for 10-bit samples). Reset gives the same values, except that `busy` is 0.
- R2: The window covers exactly G clock edges after the `start` edge. G is `gate_len` captured at `start`, and a value of 0 acts as 1. Only samples with `smp_valid` high at those edges are accepted, and `smp_cnt` counts them.
- R3: `done` rises on the edge where `busy` falls. From then until the next `start`, `done` stays high, and all four results hold while new samples are ignored.
- R4: A sample is high when it is strictly greater than the threshold captured from `thresh` at `start`. A sample equal to the threshold is not high.
- R5: A run counter counts consecutive high samples and saturates at the persistence setting P, captured from `persist` at `start`. The trigger arms on a high sample that finds the run counter already at P, so arming takes P+1 consecutive high samples.
- R6: Any accepted sample that is not high clears the run counter. A run broken before it arms therefore never arms.
- R7: An accepted sample of exactly 0 adds one to `freq_cnt` if the trigger is armed, and always disarms the trigger.
- R8: A sample from 1 up to the threshold neither counts a cycle nor disarms the trigger.
- R9: `max_val` and `min_val` follow the largest and smallest accepted sample of the window.
- R10: Cycles with `smp_valid` low change no result, no run counter and no armed state.
- R11: A `start` during an open window discards that window's state and begins a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a new measurement window |
| gate_len | input | GATE_W | Window length in clocks, captured at start |
| thresh | input | SAMPLE_W | High threshold, captured at start |
| persist | input | PERSIST_W | Persistence setting P, captured at start |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Sample value |
| busy | output | 1 | Window open |
| done | output | 1 | Results final and held |
| freq_cnt | output | CNT_W | Counted signal cycles |
| max_val | output | SAMPLE_W | Largest accepted sample |
| min_val | output | SAMPLE_W | Smallest accepted sample |
| smp_cnt | output | CNT_W | Number of accepted samples |

## Verification
The bench keeps the 10-bit sample width, but builds the block with a 16-bit gate counter, 16-bit result counters and a 4-bit persistence field. With these values, whole windows of a few to a few dozen clocks can run back to back. Each scenario can then finish and be checked in full: the window edge, the post-window hold, a window length of zero and restarts in mid-window. The full-scale sample values 0 and 1023 stay in reach, so the peak tracker is exercised at both of its reset extremes.

// File: rtl/hfm_pkg.sv
package hfm_pkg;

    // How one accepted sample is seen by the trigger
    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_BAND = 2'd1,
        CLS_HIGH = 2'd2
    } smp_class_e;

    // Trigger state carried between samples
    typedef struct packed {
        logic armed;
        logic at_limit;
    } trig_flags_t;

    function automatic smp_class_e classify(input int unsigned value,
                                            input int unsigned limit);
        if (value > limit)
            return CLS_HIGH;
        else if (value == 0)
            return CLS_ZERO;
        else
            return CLS_BAND;
    endfunction

endpackage

// File: rtl/hfm_gate_timer.sv
module hfm_gate_timer #(
    parameter int GATE_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [GATE_W-1:0] gate_len,
    output logic              busy,
    output logic              done
);
    logic [GATE_W-1:0] elapsed_q;
    logic [GATE_W-1:0] limit_q;
    logic              last_edge;

    assign last_edge = (elapsed_q == limit_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            elapsed_q <= '0;
            limit_q   <= GATE_W'(1);
        end else if (start) begin
            busy      <= 1'b1;
            done      <= 1'b0;
            elapsed_q <= '0;
            limit_q   <= (gate_len == '0) ? GATE_W'(1) : gate_len;
        end else if (busy) begin
            if (last_edge) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else begin
                elapsed_q <= elapsed_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hfm_schmitt.sv
module hfm_schmitt
    import hfm_pkg::*;
#(
    parameter int SAMPLE_W    = 10,
    parameter int PERSIST_W   = 8,
    parameter int CNT_W       = 32,
    parameter int DEF_THRESH  = 4,
    parameter int DEF_PERSIST = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [SAMPLE_W-1:0]  thresh,
    input  logic [PERSIST_W-1:0] persist,
    input  logic                 take,
    input  logic [SAMPLE_W-1:0]  sample,
    output logic [CNT_W-1:0]     freq_cnt
);
    logic [SAMPLE_W-1:0]  thr_q;
    logic [PERSIST_W-1:0] per_q;
    logic [PERSIST_W-1:0] run_q;
    trig_flags_t          flags;
    logic                 armed_q;
    smp_class_e           cls;

    always_comb begin
        cls            = classify(int'(sample), int'(thr_q));
        flags.armed    = armed_q;
        flags.at_limit = (run_q == per_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q    <= SAMPLE_W'(DEF_THRESH);
            per_q    <= PERSIST_W'(DEF_PERSIST);
            run_q    <= '0;
            armed_q  <= 1'b0;
            freq_cnt <= '0;
        end else if (start) begin
            thr_q    <= thresh;
            per_q    <= persist;
            run_q    <= '0;
            armed_q  <= 1'b0;
            freq_cnt <= '0;
        end else if (take) begin
            unique case (cls)
                CLS_HIGH: begin
                    if (flags.at_limit)
                        armed_q <= 1'b1;
                    else
                        run_q <= run_q + 1'b1;
                end
                CLS_ZERO: begin
                    run_q   <= '0;
                    armed_q <= 1'b0;
                    if (flags.armed)
                        freq_cnt <= freq_cnt + 1'b1;
                end
                default: run_q <= '0;
            endcase
        end
    end
endmodule

// File: rtl/hfm_peak.sv
module hfm_peak #(
    parameter int SAMPLE_W = 10,
    parameter int CNT_W    = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                take,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [SAMPLE_W-1:0] max_val,
    output logic [SAMPLE_W-1:0] min_val,
    output logic [CNT_W-1:0]    smp_cnt
);
    always_ff @(posedge clk) begin
        if (rst || start) begin
            max_val <= '0;
            min_val <= '1;
            smp_cnt <= '0;
        end else if (take) begin
            smp_cnt <= smp_cnt + 1'b1;
            if (sample > max_val) max_val <= sample;
            if (sample < min_val) min_val <= sample;
        end
    end
endmodule

// File: rtl/hyst_freq_meter.sv
module hyst_freq_meter #(
    parameter int SAMPLE_W    = 10,
    parameter int GATE_W      = 32,
    parameter int CNT_W       = 32,
    parameter int PERSIST_W   = 8,
    parameter int DEF_THRESH  = 4,
    parameter int DEF_PERSIST = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [GATE_W-1:0]    gate_len,
    input  logic [SAMPLE_W-1:0]  thresh,
    input  logic [PERSIST_W-1:0] persist,
    input  logic                 smp_valid,
    input  logic [SAMPLE_W-1:0]  smp_data,
    output logic                 busy,
    output logic                 done,
    output logic [CNT_W-1:0]     freq_cnt,
    output logic [SAMPLE_W-1:0]  max_val,
    output logic [SAMPLE_W-1:0]  min_val,
    output logic [CNT_W-1:0]     smp_cnt
);
    logic take;

    // A sample counts only inside an open window and not on a start edge
    assign take = smp_valid && busy && !start;

    hfm_gate_timer #(.GATE_W(GATE_W)) u_gate (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .gate_len (gate_len),
        .busy     (busy),
        .done     (done)
    );

    hfm_schmitt #(
        .SAMPLE_W    (SAMPLE_W),
        .PERSIST_W   (PERSIST_W),
        .CNT_W       (CNT_W),
        .DEF_THRESH  (DEF_THRESH),
        .DEF_PERSIST (DEF_PERSIST)
    ) u_trig (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .thresh   (thresh),
        .persist  (persist),
        .take     (take),
        .sample   (smp_data),
        .freq_cnt (freq_cnt)
    );

    hfm_peak #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_peak (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .take    (take),
        .sample  (smp_data),
        .max_val (max_val),
        .min_val (min_val),
        .smp_cnt (smp_cnt)
    );
endmodule

// File: rtl/hfm_checker.sv
module hfm_checker #(
    parameter int SAMPLE_W  = 10,
    parameter int GATE_W    = 32,
    parameter int CNT_W     = 32,
    parameter int PERSIST_W = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic [GATE_W-1:0]    gate_len,
    input logic                 smp_valid,
    input logic                 busy,
    input logic                 done,
    input logic [CNT_W-1:0]     freq_cnt,
    input logic [SAMPLE_W-1:0]  max_val,
    input logic [SAMPLE_W-1:0]  min_val,
    input logic [CNT_W-1:0]     smp_cnt
);
    logic [GATE_W-1:0] seen_q;
    logic [GATE_W-1:0] want_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
            want_q <= '0;
        end else if (start) begin
            seen_q <= '0;
            want_q <= (gate_len == '0) ? GATE_W'(1) : gate_len;
        end else if (busy) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    a_r1_start_clears: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && !done && freq_cnt == '0 && smp_cnt == '0
                   && max_val == '0 && min_val == '1));

    a_r2_window_length: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !start) |-> (seen_q == want_q));

    a_r3_done_excl_busy: assert property (@(posedge clk) disable iff (rst)
        !(done && busy));

    a_r3_hold_when_done: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(freq_cnt) && $stable(smp_cnt)
                              && $stable(max_val) && $stable(min_val)));

    a_r7_freq_step: assert property (@(posedge clk) disable iff (rst)
        !start |=> (freq_cnt == $past(freq_cnt)
                    || freq_cnt == $past(freq_cnt) + 1'b1));

    a_r9_min_le_max: assert property (@(posedge clk) disable iff (rst)
        (smp_cnt != '0) |-> (min_val <= max_val));

    a_r10_idle_no_count: assert property (@(posedge clk) disable iff (rst)
        (!smp_valid && !start) |=> $stable(smp_cnt));
endmodule

bind hyst_freq_meter hfm_checker #(
    .SAMPLE_W  (SAMPLE_W),
    .GATE_W    (GATE_W),
    .CNT_W     (CNT_W),
    .PERSIST_W (PERSIST_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .gate_len  (gate_len),
    .smp_valid (smp_valid),
    .busy      (busy),
    .done      (done),
    .freq_cnt  (freq_cnt),
    .max_val   (max_val),
    .min_val   (min_val),
    .smp_cnt   (smp_cnt)
);

// File: tb/hyst_freq_meter_tb_top.sv
module hyst_freq_meter_tb_top;
    localparam int SW = 10;
    localparam int GW = 16;
    localparam int CW = 16;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [GW-1:0] gate_len = '0;
    logic [SW-1:0] thresh = '0;
    logic [PW-1:0] persist = '0;
    logic          smp_valid = 1'b0;
    logic [SW-1:0] smp_data = '0;
    logic          busy, done;
    logic [CW-1:0] freq_cnt, smp_cnt;
    logic [SW-1:0] max_val, min_val;

    int checks = 0;
    int fails  = 0;

    logic [SW-1:0] seq_d [64];
    logic          seq_v [64];
    int            seq_n = 0;

    hyst_freq_meter #(.SAMPLE_W(SW), .GATE_W(GW), .CNT_W(CW), .PERSIST_W(PW)) dut_i (
        .clk(clk), .rst(rst), .start(start), .gate_len(gate_len),
        .thresh(thresh), .persist(persist), .smp_valid(smp_valid),
        .smp_data(smp_data), .busy(busy), .done(done), .freq_cnt(freq_cnt),
        .max_val(max_val), .min_val(min_val), .smp_cnt(smp_cnt)
    );

    always #10 clk = ~clk;

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run hung, actual running expected finished");
        report();
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_seq();
        seq_n = 0;
    endtask

    task automatic add(input int d);
        seq_d[seq_n] = SW'(d);
        seq_v[seq_n] = 1'b1;
        seq_n++;
    endtask

    task automatic gap();
        seq_d[seq_n] = SW'(1023);
        seq_v[seq_n] = 1'b0;
        seq_n++;
    endtask

    task automatic pulse_start(input int gate, input int thr, input int per);
        @(negedge clk);
        gate_len  = GW'(gate);
        thresh    = SW'(thr);
        persist   = PW'(per);
        start     = 1'b1;
        smp_valid = 1'b1;
        smp_data  = SW'(0);
        @(posedge clk);
        @(negedge clk);
        start     = 1'b0;
        smp_valid = 1'b0;
        // R1: state after the start edge
        chk(busy && !done && freq_cnt == 0 && smp_cnt == 0 && max_val == 0
            && min_val == 1023, "R1 start clears", int'(min_val), 1023);
    endtask

    // Runs one full window over the loaded sequence and checks all results
    task automatic run_window(input string tag, input int gate, input int thr, input int per);
        int run = 0, f = 0, mx = 0, mn = 1023, c = 0;
        bit armed = 0;
        pulse_start(gate, thr, per);
        for (int i = 0; i < seq_n; i++) begin
            if (i > 0) @(negedge clk);
            smp_valid = seq_v[i];
            smp_data  = seq_d[i];
            @(posedge clk);
        end
        @(negedge clk);
        smp_valid = 1'b0;
        for (int i = 0; i < seq_n; i++) begin
            if (seq_v[i]) begin
                int d = int'(seq_d[i]);
                c++;
                if (d > mx) mx = d;
                if (d < mn) mn = d;
                if (d > thr) begin
                    if (run == per) armed = 1; else run++;
                end else begin
                    run = 0;
                    if (d == 0) begin
                        if (armed) f++;
                        armed = 0;
                    end
                end
            end
        end
        chk(done == 1'b1, {tag, " R3 done at window end"}, int'(done), 1);
        chk(busy == 1'b0, {tag, " R2 busy closed after gate"}, int'(busy), 0);
        chk(int'(freq_cnt) == f, {tag, " R7 frequency"}, int'(freq_cnt), f);
        chk(int'(max_val) == mx, {tag, " R9 max"}, int'(max_val), mx);
        chk(int'(min_val) == mn, {tag, " R9 min"}, int'(min_val), mn);
        chk(int'(smp_cnt) == c, {tag, " R2 sample count"}, int'(smp_cnt), c);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!busy && !done && freq_cnt == 0 && smp_cnt == 0 && max_val == 0
            && min_val == 1023, "R1 reset state", int'(busy), 0);
    endtask

    task automatic t_basic_cycles();
        // R5 R7: three highs arm with P=2, zero counts; two highs do not arm
        clear_seq();
        add(5); add(5); add(5); add(0);
        add(6); add(6); add(6); add(0);
        add(5); add(5); add(0);
        run_window("basic", seq_n, 4, 2);
        chk(freq_cnt == 2, "R5 two armed cycles", int'(freq_cnt), 2);
    endtask

    task automatic t_dead_band();
        // R8: band samples keep the arm; R6: a band sample breaks a run
        clear_seq();
        add(9); add(9); add(9); add(3); add(4); add(0);
        add(9); add(9); add(3); add(9); add(0);
        run_window("band", seq_n, 4, 2);
        chk(freq_cnt == 1, "R8 R6 band keeps arm, break resets run", int'(freq_cnt), 1);
    endtask

    task automatic t_threshold();
        // R4: equal to threshold is not high; above it is
        clear_seq();
        add(100); add(100); add(100); add(0);
        add(101); add(101); add(101); add(0);
        run_window("thresh", seq_n, 100, 2);
        chk(freq_cnt == 1, "R4 strict threshold", int'(freq_cnt), 1);
    endtask

    task automatic t_persist_zero();
        // R5: P=0 arms on a single high sample
        clear_seq();
        add(7); add(0); add(7); add(0); add(0);
        run_window("p0", seq_n, 4, 0);
        chk(freq_cnt == 2, "R5 single-sample arming", int'(freq_cnt), 2);
    endtask

    task automatic t_gaps_and_extremes();
        // R10: invalid slots ignored (they carry 1023, so max would show it)
        clear_seq();
        add(0); gap(); add(600); add(600); gap(); add(600); gap(); add(0); add(3);
        run_window("gaps", seq_n, 4, 2);
        chk(max_val == 600, "R10 invalid slots ignored", int'(max_val), 600);
        clear_seq();
        add(1023); add(512); add(0); add(1023);
        run_window("extremes", seq_n, 4, 2);
    endtask

    task automatic t_hold_after_done();
        logic [CW-1:0] f0, c0;
        logic [SW-1:0] mx0, mn0;
        clear_seq();
        add(50); add(50); add(50);
        run_window("hold", seq_n, 4, 2);
        f0 = freq_cnt; c0 = smp_cnt; mx0 = max_val; mn0 = min_val;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            smp_valid = 1'b1;
            smp_data  = (i % 2 == 0) ? SW'(0) : SW'(1023);
        end
        @(negedge clk);
        smp_valid = 1'b0;
        chk(done && freq_cnt == f0 && smp_cnt == c0 && max_val == mx0 && min_val == mn0,
            "R3 results held after window", int'(smp_cnt), int'(c0));
    endtask

    task automatic t_gate_zero();
        // R2: gate length 0 behaves as 1
        clear_seq();
        add(77);
        run_window("gate0", 0, 4, 2);
    endtask

    task automatic t_restart();
        // R11: a start mid-window discards the first window's samples
        pulse_start(40, 4, 0);
        for (int i = 0; i < 4; i++) begin
            if (i > 0) @(negedge clk);
            smp_valid = 1'b1;
            smp_data  = (i % 2 == 0) ? SW'(900) : SW'(0);
            @(posedge clk);
        end
        clear_seq();
        add(1); add(2); add(3);
        run_window("restart", seq_n, 4, 0);
        chk(freq_cnt == 0 && max_val == 3, "R11 restart discards old window",
            int'(max_val), 3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic_cycles();
        t_dead_band();
        t_threshold();
        t_persist_zero();
        t_gaps_and_extremes();
        t_hold_after_done();
        t_gate_zero();
        t_restart();
        report();
        $finish;
    end
endmodule